// File: doc/BRIEF.md
# Register-Backed Stack-Top Cache

This block holds the traversal stack of a single ray. The newest entries, up to a parameter `N` (4 by default), live in a small shift-register file on chip. Everything deeper sits in a private, linear region of external memory that belongs to this ray alone. Entry number `d` counts from the bottom of the stack, starting at 0, and is stored at word address `base + d`. A push onto a full register file first moves the oldest resident entry out to memory. A pop from an empty register file fetches one entry back from memory. These transfers use a single-word request port. The port keeps the request raised until a one-cycle response arrives.

When the ray is parked, a flush command writes every resident entry out to memory. The register file is then empty, but the total depth is kept. A reload command later resumes a ray by setting its base address and depth. No entry is resident after a reload, so each pop then refills from memory, one entry at a time. While a memory transfer is in flight, `ready_o` is low and all commands are ignored.

Top module: `stc_stack_top_cache`

## Requirements
- R1: After reset the depth is 0, the resident count is 0, `ready_o` is 1 and `mem_req_o` is 0.
- R2: A push while fewer than `N` entries are resident is held on chip with no memory request. Depth and resident count each rise by 1 at the accepting edge.
- R3: A push while `N` entries are resident issues a write (`mem_we_o`=1) of the oldest resident entry to `base + depth - N`. `ready_o` stays low until the response. The new entry is then taken in, the resident count stays `N` and the depth rises by 1.
- R4: A pop with at least one resident entry returns the newest entry on `pop_data_o`. `pop_valid_o` is high for exactly one cycle, in the cycle after the accepting edge. Depth and resident count each fall by 1.
- R5: A pop with no resident entry and a non-zero depth issues a read (`mem_we_o`=0) of `base + depth - 1`. The read data appears with `pop_valid_o` in the cycle after the response, and the depth falls by 1.
- R6: A pop with depth 0 raises `pop_empty_o` for one cycle. It does not raise `pop_valid_o`, makes no memory request and leaves the depth at 0.
- R7: A flush writes the resident entries oldest first, each to `base + depth - resident`, with the resident count falling after each response. It ends with a resident count of 0 and the depth unchanged. A flush with nothing resident completes with no memory traffic.
- R8: A reload sets the base to `reload_base_i` and the depth to `reload_depth_i`, and clears the resident count, in one cycle.
- R9: While `ready_o` is low, push, pop, flush and reload have no effect.
- R10: A memory request keeps `mem_addr_o`, `mem_we_o` and `mem_wdata_o` steady until the cycle in which `mem_rsp_i` is seen.
- R11: When several commands are raised together, only one is acted on. The priority from highest is flush, then reload, then push, then pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | Push command |
| pop_i | input | 1 | Pop command |
| flush_i | input | 1 | Write all resident entries to memory |
| reload_i | input | 1 | Resume a ray from memory |
| push_data_i | input | 32 | Node index to push |
| reload_base_i | input | 32 | Stack region base word address for reload |
| reload_depth_i | input | 16 | Stack depth for reload |
| ready_o | output | 1 | Commands accepted this cycle |
| pop_valid_o | output | 1 | Pop result valid (one cycle) |
| pop_empty_o | output | 1 | Pop hit an empty stack (one cycle) |
| pop_data_o | output | 32 | Popped node index |
| depth_o | output | 16 | Total stack depth |
| resident_o | output | 3 | Entries held in registers |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rsp_i | input | 1 | Memory response (one cycle) |
| mem_rdata_i | input | 32 | Read data, valid with the response |

## Verification
The assertions check these properties on every cycle:
- the resident count stays at or below both `N` and the depth;
- memory requests hold steady until their response;
- the depth does not move while a transfer is pending;
- an accepted on-chip push raises the depth by one;
- a full push always starts a write;
- the valid and empty pop flags never coincide.

Some behaviour can only be shown by the bench's scenarios, which compare against a model memory:
- the exact spill, fill and flush addresses and their oldest-first order;
- that data pushed, spilled, flushed and refilled comes back in LIFO order;
- that a reloaded ray reads its region from the right base;
- the command priority.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2,
    ST_FLUSH = 2'd3
  } stc_state_e;
endpackage

// File: rtl/stc_rst_sync.sv
module stc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/stc_regfile.sv
module stc_regfile #(
  parameter int N  = 4,
  parameter int DW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_in,
  input  logic          shift_out,
  input  logic [DW-1:0] din,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] top_data
);
  logic [DW-1:0] slot_q [N];
  logic [DW-1:0] slot_d [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_comb begin
      slot_d[g] = slot_q[g];
      if (shift_in) begin
        if (g == 0) slot_d[g] = din;
        else        slot_d[g] = slot_q[(g == 0) ? 0 : g-1];
      end else if (shift_out) begin
        if (g < N-1) slot_d[g] = slot_q[(g < N-1) ? g+1 : g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   slot_q[g] <= '0;
      else if (shift_in || shift_out) slot_q[g] <= slot_d[g];
    end
  end

  assign rd_data  = slot_q[rd_idx];
  assign top_data = slot_q[0];

  a_r11_single_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_in && shift_out));
endmodule

// File: rtl/stc_ctrl.sv
module stc_ctrl
  import stc_pkg::*;
#(
  parameter int N       = 4,
  parameter int DW      = 32,
  parameter int AW      = 32,
  parameter int DEPTH_W = 16,
  localparam int CW = $clog2(N+1),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic               flush_i,
  input  logic               reload_i,
  input  logic [DW-1:0]      push_data_i,
  input  logic [AW-1:0]      reload_base_i,
  input  logic [DEPTH_W-1:0] reload_depth_i,
  output logic               ready_o,
  output logic               pop_valid_o,
  output logic               pop_empty_o,
  output logic [DW-1:0]      pop_data_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic [CW-1:0]      resident_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic               mem_rsp_i,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               reg_push,
  output logic               reg_pop,
  output logic [DW-1:0]      reg_din,
  output logic [IW-1:0]      reg_rd_idx,
  input  logic [DW-1:0]      reg_rd_data,
  input  logic [DW-1:0]      reg_top
);
  localparam logic [CW-1:0] RES_FULL = CW'(N);

  stc_state_e         state_q, state_d;
  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic [CW-1:0]      res_q, res_d;
  logic [AW-1:0]      base_q, base_d;
  logic [DW-1:0]      pend_q, pend_d;
  logic               pv_q, pv_d, pe_q, pe_d;
  logic [DW-1:0]      pdata_q, pdata_d;
  logic [AW-1:0]      depth_ext;

  assign depth_ext = AW'(depth_q);

  // next-state process
  always_comb begin
    state_d  = state_q;
    depth_d  = depth_q;
    res_d    = res_q;
    base_d   = base_q;
    pend_d   = pend_q;
    pv_d     = 1'b0;
    pe_d     = 1'b0;
    pdata_d  = pdata_q;
    reg_push = 1'b0;
    reg_pop  = 1'b0;
    reg_din  = push_data_i;
    unique case (state_q)
      ST_IDLE: begin
        if (flush_i) begin
          if (res_q != '0) state_d = ST_FLUSH;
        end else if (reload_i) begin
          base_d  = reload_base_i;
          depth_d = reload_depth_i;
          res_d   = '0;
        end else if (push_i) begin
          if (res_q == RES_FULL) begin
            pend_d  = push_data_i;
            state_d = ST_SPILL;
          end else begin
            reg_push = 1'b1;
            res_d    = res_q + 1'b1;
            depth_d  = depth_q + 1'b1;
          end
        end else if (pop_i) begin
          if (res_q != '0) begin
            reg_pop = 1'b1;
            pv_d    = 1'b1;
            pdata_d = reg_top;
            res_d   = res_q - 1'b1;
            depth_d = depth_q - 1'b1;
          end else if (depth_q != '0) begin
            state_d = ST_FILL;
          end else begin
            pe_d = 1'b1;
          end
        end
      end
      ST_SPILL: if (mem_rsp_i) begin
        reg_push = 1'b1;
        reg_din  = pend_q;
        depth_d  = depth_q + 1'b1;
        state_d  = ST_IDLE;
      end
      ST_FILL: if (mem_rsp_i) begin
        pv_d    = 1'b1;
        pdata_d = mem_rdata_i;
        depth_d = depth_q - 1'b1;
        state_d = ST_IDLE;
      end
      ST_FLUSH: if (mem_rsp_i) begin
        res_d = res_q - 1'b1;
        if (res_q == CW'(1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // memory request decode
  always_comb begin
    reg_rd_idx  = IW'(res_q - 1'b1);
    mem_wdata_o = reg_rd_data;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_q + depth_ext - AW'(res_q);
    unique case (state_q)
      ST_SPILL: begin
        reg_rd_idx = IW'(N-1);
        mem_we_o   = 1'b1;
        mem_addr_o = base_q + depth_ext - AW'(N);
      end
      ST_FLUSH: mem_we_o = 1'b1;
      ST_FILL:  mem_addr_o = base_q + depth_ext - AW'(1);
      default:  ;
    endcase
  end

  assign mem_req_o = (state_q != ST_IDLE);
  assign ready_o   = (state_q == ST_IDLE);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      depth_q <= '0;
      res_q   <= '0;
      base_q  <= '0;
      pend_q  <= '0;
      pv_q    <= 1'b0;
      pe_q    <= 1'b0;
      pdata_q <= '0;
    end else begin
      state_q <= state_d;
      depth_q <= depth_d;
      res_q   <= res_d;
      base_q  <= base_d;
      pv_q    <= pv_d;
      pe_q    <= pe_d;
      if (state_q == ST_IDLE) pend_q  <= pend_d;
      if (pv_d)               pdata_q <= pdata_d;
    end
  end

  assign pop_valid_o = pv_q;
  assign pop_empty_o = pe_q;
  assign pop_data_o  = pdata_q;
  assign depth_o     = depth_q;
  assign resident_o  = res_q;

  a_r2_resident_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q <= RES_FULL) && (DEPTH_W'(res_q) <= depth_q));
  a_r2_onchip_push: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && push_i && !flush_i && !reload_i && res_q != RES_FULL)
      |=> (depth_q == $past(depth_q) + 1'b1) && !mem_req_o);
  a_r3_spill_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && push_i && !flush_i && !reload_i && res_q == RES_FULL)
      |=> (mem_req_o && mem_we_o && !ready_o));
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_valid_o && pop_empty_o));
  a_r6_empty_depth: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty_o |-> (depth_q == '0));
  a_r9_depth_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rsp_i) |=> $stable(depth_q));
  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rsp_i)
      |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
  a_r7_flush_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLUSH) |-> (mem_we_o && res_q != '0));
endmodule

// File: rtl/stc_stack_top_cache.sv
module stc_stack_top_cache #(
  parameter int N       = 4,
  parameter int DW      = 32,
  parameter int AW      = 32,
  parameter int DEPTH_W = 16,
  localparam int CW = $clog2(N+1),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic               flush_i,
  input  logic               reload_i,
  input  logic [DW-1:0]      push_data_i,
  input  logic [AW-1:0]      reload_base_i,
  input  logic [DEPTH_W-1:0] reload_depth_i,
  output logic               ready_o,
  output logic               pop_valid_o,
  output logic               pop_empty_o,
  output logic [DW-1:0]      pop_data_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic [CW-1:0]      resident_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic               mem_rsp_i,
  input  logic [DW-1:0]      mem_rdata_i
);
  logic          rst_n_s;
  logic          reg_push, reg_pop;
  logic [DW-1:0] reg_din, reg_rd_data, reg_top;
  logic [IW-1:0] reg_rd_idx;

  stc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  stc_regfile #(.N(N), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .shift_in (reg_push),
    .shift_out(reg_pop),
    .din      (reg_din),
    .rd_idx   (reg_rd_idx),
    .rd_data  (reg_rd_data),
    .top_data (reg_top)
  );

  stc_ctrl #(.N(N), .DW(DW), .AW(AW), .DEPTH_W(DEPTH_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .push_i         (push_i),
    .pop_i          (pop_i),
    .flush_i        (flush_i),
    .reload_i       (reload_i),
    .push_data_i    (push_data_i),
    .reload_base_i  (reload_base_i),
    .reload_depth_i (reload_depth_i),
    .ready_o        (ready_o),
    .pop_valid_o    (pop_valid_o),
    .pop_empty_o    (pop_empty_o),
    .pop_data_o     (pop_data_o),
    .depth_o        (depth_o),
    .resident_o     (resident_o),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .mem_rsp_i      (mem_rsp_i),
    .mem_rdata_i    (mem_rdata_i),
    .reg_push       (reg_push),
    .reg_pop        (reg_pop),
    .reg_din        (reg_din),
    .reg_rd_idx     (reg_rd_idx),
    .reg_rd_data    (reg_rd_data),
    .reg_top        (reg_top)
  );
endmodule

// File: tb/tb_stc_stack_top_cache.sv
module tb_stc_stack_top_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, pop_i = 0, flush_i = 0, reload_i = 0;
  logic [31:0] push_data_i = '0, reload_base_i = '0;
  logic [15:0] reload_depth_i = '0;
  logic        ready_o, pop_valid_o, pop_empty_o;
  logic [31:0] pop_data_o;
  logic [15:0] depth_o;
  logic [2:0]  resident_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_rsp_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [256];
  logic [31:0] wr_addr [32];
  logic [31:0] wr_data [32];
  int wr_cnt = 0, rd_cnt = 0, lat = 0;

  always #10 clk = ~clk;

  stc_stack_top_cache dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .flush_i(flush_i),
    .reload_i(reload_i), .push_data_i(push_data_i), .reload_base_i(reload_base_i),
    .reload_depth_i(reload_depth_i), .ready_o(ready_o), .pop_valid_o(pop_valid_o),
    .pop_empty_o(pop_empty_o), .pop_data_o(pop_data_o), .depth_o(depth_o),
    .resident_o(resident_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rsp_i(mem_rsp_i),
    .mem_rdata_i(mem_rdata_i)
  );

  // memory model: response two cycles after a request is seen
  always @(negedge clk) begin
    if (mem_rsp_i) begin
      mem_rsp_i <= 1'b0;
      lat = 0;
    end else if (mem_req_o) begin
      lat++;
      if (lat == 2) begin
        mem_rsp_i <= 1'b1;
        if (mem_we_o) begin
          mem[mem_addr_o[7:0]] = mem_wdata_o;
          wr_addr[wr_cnt % 32] = mem_addr_o;
          wr_data[wr_cnt % 32] = mem_wdata_o;
          wr_cnt++;
        end else begin
          mem_rdata_i <= mem[mem_addr_o[7:0]];
          rd_cnt++;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!ready_o) @(negedge clk);
  endtask

  task automatic cmd(input bit pu, input bit po, input bit fl, input bit rl, input logic [31:0] d);
    wait_ready();
    push_i = pu; pop_i = po; flush_i = fl; reload_i = rl; push_data_i = d;
    @(negedge clk);
    push_i = 0; pop_i = 0; flush_i = 0; reload_i = 0;
  endtask

  task automatic do_reload(input logic [31:0] b, input logic [15:0] dp);
    reload_base_i = b; reload_depth_i = dp;
    cmd(0, 0, 0, 1, '0);
  endtask

  task automatic pop_get(output logic [31:0] d, output bit v, output bit e);
    cmd(0, 1, 0, 0, '0);
    v = 0; e = 0; d = '0;
    for (int i = 0; i < 20; i++) begin
      if (pop_valid_o || pop_empty_o) break;
      @(negedge clk);
    end
    v = pop_valid_o; e = pop_empty_o; d = pop_data_o;
    @(negedge clk);
    check(!pop_valid_o && !pop_empty_o, "R4 flag one cycle", {31'd0, pop_valid_o | pop_empty_o}, 32'd0);
  endtask

  task automatic t_reset();
    check(depth_o == 0, "R1 depth", depth_o, 0);
    check(resident_o == 0, "R1 resident", resident_o, 0);
    check(ready_o && !mem_req_o, "R1 ready/req", {ready_o, mem_req_o}, 32'h2);
  endtask

  task automatic t_onchip_push();
    int w0;
    do_reload(32'h10, 0);
    check(depth_o == 0 && resident_o == 0, "R8 reload zero", depth_o, 0);
    w0 = wr_cnt;
    cmd(1, 0, 0, 0, 32'hA); cmd(1, 0, 0, 0, 32'hB); cmd(1, 0, 0, 0, 32'hC); cmd(1, 0, 0, 0, 32'hD);
    check(depth_o == 4, "R2 depth", depth_o, 4);
    check(resident_o == 4, "R2 resident", resident_o, 4);
    check(wr_cnt == w0 && !mem_req_o, "R2 no memory traffic", wr_cnt - w0, 0);
  endtask

  task automatic t_spill();
    int w0;
    bit saw_pv;
    w0 = wr_cnt; saw_pv = 0;
    cmd(1, 0, 0, 0, 32'hE);
    check(!ready_o && mem_req_o && mem_we_o, "R3 spill request", {ready_o, mem_req_o, mem_we_o}, 3'b011);
    check(mem_addr_o == 32'h10, "R10 spill addr", mem_addr_o, 32'h10);
    // commands while busy must be ignored
    pop_i = 1; push_i = 1; push_data_i = 32'h99;
    @(negedge clk);
    pop_i = 0; push_i = 0;
    check(mem_addr_o == 32'h10 || ready_o, "R10 addr held", mem_addr_o, 32'h10);
    while (!ready_o) begin
      if (pop_valid_o) saw_pv = 1;
      @(negedge clk);
    end
    @(negedge clk);
    check(!saw_pv && !pop_valid_o, "R9 pop ignored while busy", {31'd0, saw_pv}, 0);
    check(wr_cnt == w0 + 1 && wr_addr[w0 % 32] == 32'h10, "R3 spill addr", wr_addr[w0 % 32], 32'h10);
    check(wr_data[w0 % 32] == 32'hA, "R3 spill oldest", wr_data[w0 % 32], 32'hA);
    check(depth_o == 5, "R3/R9 depth", depth_o, 5);
    check(resident_o == 4, "R3 resident", resident_o, 4);
  endtask

  task automatic t_reg_pop();
    logic [31:0] d; bit v, e;
    pop_get(d, v, e);
    check(v && d == 32'hE, "R4 pop newest", d, 32'hE);
    pop_get(d, v, e);
    check(v && d == 32'hD, "R4 pop second", d, 32'hD);
    check(depth_o == 3 && resident_o == 2, "R4 counts", {depth_o, 13'd0, resident_o}, {16'd3, 16'd2});
  endtask

  task automatic t_flush();
    int w0;
    w0 = wr_cnt;
    cmd(0, 0, 1, 0, '0);
    wait_ready();
    check(wr_cnt == w0 + 2, "R7 flush writes", wr_cnt - w0, 2);
    check(wr_addr[w0 % 32] == 32'h11 && wr_data[w0 % 32] == 32'hB, "R7 oldest first", wr_data[w0 % 32], 32'hB);
    check(wr_addr[(w0+1) % 32] == 32'h12 && wr_data[(w0+1) % 32] == 32'hC, "R7 second write", wr_data[(w0+1) % 32], 32'hC);
    check(resident_o == 0 && depth_o == 3, "R7 counts", {depth_o, 13'd0, resident_o}, {16'd3, 16'd0});
    w0 = wr_cnt;
    cmd(0, 0, 1, 0, '0);
    check(ready_o && wr_cnt == w0 && !mem_req_o, "R7 empty flush", wr_cnt - w0, 0);
  endtask

  task automatic t_fill();
    logic [31:0] d; bit v, e;
    int r0;
    r0 = rd_cnt;
    pop_get(d, v, e);
    check(v && d == 32'hC, "R5 fill top", d, 32'hC);
    check(rd_cnt == r0 + 1 && depth_o == 2, "R5 depth", depth_o, 2);
    pop_get(d, v, e);
    check(v && d == 32'hB, "R5 fill next", d, 32'hB);
    pop_get(d, v, e);
    check(v && d == 32'hA, "R5 fill spilled", d, 32'hA);
    r0 = rd_cnt;
    pop_get(d, v, e);
    check(e && !v, "R6 empty flag", {30'd0, e, v}, 32'h2);
    check(depth_o == 0 && rd_cnt == r0, "R6 no traffic", rd_cnt - r0, 0);
  endtask

  task automatic t_reload();
    logic [31:0] d; bit v, e;
    mem[8'h80] = 32'h1111; mem[8'h81] = 32'h2222;
    do_reload(32'h80, 2);
    check(depth_o == 2 && resident_o == 0, "R8 reload state", depth_o, 2);
    pop_get(d, v, e);
    check(v && d == 32'h2222, "R8 reload top", d, 32'h2222);
    pop_get(d, v, e);
    check(v && d == 32'h1111, "R8 reload bottom", d, 32'h1111);
  endtask

  task automatic t_priority();
    logic [31:0] d; bit v, e;
    int w0;
    cmd(1, 0, 0, 0, 32'h51);
    cmd(1, 1, 0, 0, 32'h52);
    check(!pop_valid_o && depth_o == 2 && resident_o == 2, "R11 push over pop", depth_o, 2);
    w0 = wr_cnt;
    cmd(1, 0, 1, 0, 32'h53);
    wait_ready();
    check(wr_cnt == w0 + 2 && depth_o == 2 && resident_o == 0, "R11 flush over push", depth_o, 2);
    check(wr_addr[(w0+1) % 32] == 32'h81 && wr_data[(w0+1) % 32] == 32'h52, "R11 flushed top", wr_data[(w0+1) % 32], 32'h52);
    reload_base_i = 32'h20; reload_depth_i = 16'd7;
    cmd(1, 0, 0, 1, 32'h54);
    check(depth_o == 7 && resident_o == 0, "R11 reload over push", depth_o, 7);
    do_reload(32'h80, 2);
    pop_get(d, v, e);
    check(v && d == 32'h52, "R11 data after flush", d, 32'h52);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_onchip_push();
    t_spill();
    t_reg_pop();
    t_flush();
    t_fill();
    t_reload();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule